// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Process Tags

This block turns a 32-bit virtual address into a physical address in the same cycle. It holds a small set of translations, 64 by default, and every slot is searched at once. Each translation is tagged with a 6-bit process identifier. Translations owned by different processes can therefore stay loaded side by side, and a context switch does not force a clear.

The three top address bits decide how an address is handled. Two of the four regions are mapped: the user region and the kernel-mapped region are looked up in the table. The other two are kernel physical windows, one cached and one uncached. These windows skip the table, and their physical address is the virtual address with its three top bits forced to zero. When a mapped lookup finds no entry, the block reports a miss and does nothing more. Refilling the table is left to software. Software loads one slot at a time through a write port and can invalidate every slot at once with a flush.

Top module: `xlate_tlb`

## Requirements
- R1: After reset every slot is invalid, so any mapped lookup reports a miss.
- R2: `lk_seg` decodes `lk_va[31:29]` while `lk_req` is high. The encoding is: 0xx gives 0 (user), 100 gives 1 (kernel physical cached), 101 gives 2 (kernel physical uncached), 11x gives 3 (kernel mapped).
- R3: A lookup in region 1 or region 2 never consults the table. It reports a hit with `lk_pa` equal to `{3'b000, lk_va[28:0]}`, and `lk_dirty`, `lk_ref` and `lk_rw` are all 0.
- R4: A mapped lookup hits when a valid slot holds VPN `lk_va[31:12]` and the identifier `lk_asid`. On a hit, `lk_pa` is `{PFN, lk_va[11:0]}`.
- R5: A slot whose identifier differs from `lk_asid` never matches. The lookup misses and `lk_pa` is 0.
- R6: A slot with `lk_rw`=0 is read-only. A write lookup (`lk_write`=1) that matches it raises `lk_fault` and leaves `lk_hit` low, with `lk_pa` 0. A read lookup that matches it hits.
- R7: On a match, whether it hits or faults, `lk_dirty`, `lk_ref` and `lk_rw` show the matched slot's stored bits.
- R8: A flush invalidates all slots at the next clock edge. If a write arrives in the same cycle as a flush, the write is dropped.
- R9: A write loads all fields of slot `wr_idx` at the next edge and replaces its previous contents. A slot written with `wr_valid`=0 never matches.
- R10: When several valid slots match, the slot with the lowest index supplies the result.
- R11: While `lk_req` is low, `lk_hit`, `lk_miss` and `lk_fault` are all 0. While it is high, exactly one of the three is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address |
| lk_asid | input | 6 | Identifier of the current process |
| lk_write | input | 1 | 1 = store access, 0 = load access |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | Mapped address with no matching slot |
| lk_fault | output | 1 | Store access to a read-only page |
| lk_pa | output | 32 | Physical address (0 unless hit) |
| lk_seg | output | 2 | Region class (see R2) |
| lk_dirty | output | 1 | Dirty bit of matched slot |
| lk_ref | output | 1 | Referenced bit of matched slot |
| lk_rw | output | 1 | Writable bit of matched slot |
| wr_en | input | 1 | Load slot `wr_idx` |
| wr_idx | input | 6 | Slot index |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_asid | input | 6 | Identifier to store |
| wr_pfn | input | 20 | Physical frame number to store |
| wr_dirty | input | 1 | Dirty bit to store |
| wr_ref | input | 1 | Referenced bit to store |
| wr_valid | input | 1 | Valid bit to store |
| wr_rw | input | 1 | Writable bit to store (0 = read-only) |
| flush | input | 1 | Invalidate all slots |

## Verification
A fault in the stored state, such as a stuck valid bit, a corrupted tag or a wrong frame, shows up on the lookup outputs in the same cycle that the affected page is looked up. It appears either as a hit where a miss is expected or as a wrong frame in `lk_pa`. Because the lookup is combinational, a bad write or a bad flush is visible from the first lookup after the clock edge that applied it. The random phase uses a small pool of page numbers and identifiers. This keeps slots colliding, so lowest-index selection and identifier mismatches are exercised often.

// File: rtl/xtlb_pkg.sv
// Shared types for the translation buffer.
// Assumes 32-bit virtual addresses split into a 20-bit page number and a 12-bit offset.
package xtlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFS_W  = 12;
    localparam int VPN_W  = VA_W - OFS_W;
    localparam int PFN_W  = 20;
    localparam int ASID_W = 6;
    localparam int PA_W   = PFN_W + OFS_W;
    localparam int SEGB_W = 3;

    typedef enum logic [1:0] {
        SEG_USER    = 2'd0,
        SEG_KPHYS_C = 2'd1,
        SEG_KPHYS_U = 2'd2,
        SEG_KMAP    = 2'd3
    } seg_e;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic              refd;
        logic              rw;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
    } tlb_ent_t;
endpackage

// File: rtl/xtlb_store.sv
// Slot storage: one register per slot, loaded by index or cleared all at once.
// Assumes flush has priority over a write issued in the same cycle.
module xtlb_store
    import xtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  tlb_ent_t                  wr_ent,
    output tlb_ent_t [ENTRIES-1:0]    ent_q
);
    // Per-slot register: reset clears, flush invalidates, write loads one slot.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else if (flush) begin
                ent_q[i].valid <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent_q[i] <= wr_ent;
            end
        end
    end
endmodule

// File: rtl/xtlb_match.sv
// Parallel comparators: one match flag per slot for the page number and identifier.
// Assumes only valid slots may match.
module xtlb_match
    import xtlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  tlb_ent_t [ENTRIES-1:0] ent,
    input  logic [VPN_W-1:0]       vpn,
    input  logic [ASID_W-1:0]      asid,
    output logic [ENTRIES-1:0]     match
);
    // Compare each slot against the key.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = ent[i].valid && (ent[i].vpn == vpn) && (ent[i].asid == asid);
    end
endmodule

// File: rtl/xtlb_select.sv
// Picks the lowest-index matching slot and forwards its contents.
// Assumes a zero entry is returned when nothing matches.
module xtlb_select
    import xtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  tlb_ent_t [ENTRIES-1:0] ent,
    input  logic [ENTRIES-1:0]     match,
    output logic                   any,
    output tlb_ent_t               sel_ent
);
    logic [IDX_W-1:0] sel_idx;

    // Priority encoder: scan downward so the lowest set index is kept last.
    always_comb begin
        sel_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) sel_idx = IDX_W'(i);
        end
    end

    assign any = |match;

    // Result mux: the chosen slot, or all zeros on no match.
    always_comb begin
        sel_ent = any ? ent[sel_idx] : '0;
    end
endmodule

// File: rtl/xlate_tlb.sv
// Top: region decode, table lookup, permission check and physical address forming.
// Assumes combinational lookup; the write and flush ports act at the clock edge.
module xlate_tlb
    import xtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [PA_W-1:0]   lk_pa,
    output logic [1:0]        lk_seg,
    output logic              lk_dirty,
    output logic              lk_ref,
    output logic              lk_rw,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_dirty,
    input  logic              wr_ref,
    input  logic              wr_valid,
    input  logic              wr_rw,
    input  logic              flush
);
    tlb_ent_t [ENTRIES-1:0] ent_q;
    tlb_ent_t               wr_ent;
    tlb_ent_t               sel_ent;
    logic [ENTRIES-1:0]     match;
    logic                   any;
    seg_e                   seg;
    logic                   mapped;
    logic                   denied;

    // Pack the write-port fields into one slot image.
    always_comb begin
        wr_ent.valid = wr_valid;
        wr_ent.dirty = wr_dirty;
        wr_ent.refd  = wr_ref;
        wr_ent.rw    = wr_rw;
        wr_ent.asid  = wr_asid;
        wr_ent.vpn   = wr_vpn;
        wr_ent.pfn   = wr_pfn;
    end

    xtlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_ent (wr_ent),
        .ent_q  (ent_q)
    );

    xtlb_match #(.ENTRIES(ENTRIES)) u_match (
        .ent   (ent_q),
        .vpn   (lk_va[VA_W-1:OFS_W]),
        .asid  (lk_asid),
        .match (match)
    );

    xtlb_select #(.ENTRIES(ENTRIES)) u_select (
        .ent     (ent_q),
        .match   (match),
        .any     (any),
        .sel_ent (sel_ent)
    );

    // Region decode from the three top address bits.
    always_comb begin
        unique casez (lk_va[VA_W-1 -: SEGB_W])
            3'b0??:  seg = SEG_USER;
            3'b100:  seg = SEG_KPHYS_C;
            3'b101:  seg = SEG_KPHYS_U;
            default: seg = SEG_KMAP;
        endcase
    end

    assign mapped = (seg == SEG_USER) || (seg == SEG_KMAP);
    assign denied = lk_write && !sel_ent.rw;

    // Outcome flags: bypass always hits; mapped access hits, faults or misses.
    always_comb begin
        lk_hit   = 1'b0;
        lk_miss  = 1'b0;
        lk_fault = 1'b0;
        if (lk_req) begin
            if (!mapped)      lk_hit   = 1'b1;
            else if (!any)    lk_miss  = 1'b1;
            else if (denied)  lk_fault = 1'b1;
            else              lk_hit   = 1'b1;
        end
    end

    // Physical address: window strip for bypass, frame plus offset for a mapped hit.
    always_comb begin
        lk_pa = '0;
        if (lk_hit) begin
            if (!mapped) lk_pa = {{SEGB_W{1'b0}}, lk_va[VA_W-SEGB_W-1:0]};
            else         lk_pa = {sel_ent.pfn, lk_va[OFS_W-1:0]};
        end
    end

    // Attribute outputs: matched slot's bits on a mapped request, else zero.
    always_comb begin
        lk_seg   = lk_req ? seg : SEG_USER;
        lk_dirty = lk_req && mapped && sel_ent.dirty;
        lk_ref   = lk_req && mapped && sel_ent.refd;
        lk_rw    = lk_req && mapped && sel_ent.rw;
    end
endmodule

// File: rtl/xlate_tlb_chk.sv
// Port-level checker for the translation buffer, bound into the top module.
// Assumes inputs are stable around the sampling clock edge.
module xlate_tlb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_req,
    input logic [31:0] lk_va,
    input logic        lk_write,
    input logic        lk_hit,
    input logic        lk_miss,
    input logic        lk_fault,
    input logic [31:0] lk_pa,
    input logic [1:0]  lk_seg,
    input logic        lk_rw,
    input logic        flush
);
    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> !(lk_hit || lk_miss || lk_fault));

    a_r3_bypass_window: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_va[31:30] == 2'b10) |-> (lk_hit && lk_pa == {3'b000, lk_va[28:0]}));

    a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_pa[11:0] == lk_va[11:0]);

    a_r6_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_write && !lk_rw));

    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !((lk_hit || lk_fault) && (lk_seg == 2'd0 || lk_seg == 2'd3)));

    a_r2_user_region: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !lk_va[31]) |-> lk_seg == 2'd0);
endmodule

bind xlate_tlb xlate_tlb_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_req   (lk_req),
    .lk_va    (lk_va),
    .lk_write (lk_write),
    .lk_hit   (lk_hit),
    .lk_miss  (lk_miss),
    .lk_fault (lk_fault),
    .lk_pa    (lk_pa),
    .lk_seg   (lk_seg),
    .lk_rw    (lk_rw),
    .flush    (flush)
);

// File: tb/xlate_tlb_test.sv
module xlate_tlb_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic [5:0]  lk_asid = '0;
    logic        lk_write = 1'b0;
    logic        lk_hit, lk_miss, lk_fault, lk_dirty, lk_ref, lk_rw;
    logic [31:0] lk_pa;
    logic [1:0]  lk_seg;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [19:0] wr_vpn = '0;
    logic [5:0]  wr_asid = '0;
    logic [19:0] wr_pfn = '0;
    logic        wr_dirty = 1'b0, wr_ref = 1'b0, wr_valid = 1'b0, wr_rw = 1'b0;
    logic        flush = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the slots
    logic        m_valid [64];
    logic [19:0] m_vpn   [64];
    logic [5:0]  m_asid  [64];
    logic [19:0] m_pfn   [64];
    logic        m_dirty [64];
    logic        m_ref   [64];
    logic        m_rw    [64];

    logic [19:0] pool [8] = '{20'h00010, 20'h00011, 20'h3FFFF, 20'h7FF00,
                               20'hC0001, 20'hC0002, 20'hFFFFF, 20'h80005};

    always #2.5 clk = ~clk;

    xlate_tlb uut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid),
        .lk_write(lk_write), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
        .lk_pa(lk_pa), .lk_seg(lk_seg), .lk_dirty(lk_dirty), .lk_ref(lk_ref), .lk_rw(lk_rw),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_pfn(wr_pfn),
        .wr_dirty(wr_dirty), .wr_ref(wr_ref), .wr_valid(wr_valid), .wr_rw(wr_rw),
        .flush(flush)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 64; i++) m_valid[i] = 1'b0;
    endtask

    // Expected outputs packed as {hit,miss,fault,seg[1:0],dirty,ref,rw,pa[31:0]}
    function automatic logic [39:0] expect_out(input logic req, input logic [31:0] va,
                                               input logic [5:0] asid, input logic wr);
        logic [1:0] seg;
        logic mapped;
        int found;
        logic h, m, f, d, r, w;
        logic [31:0] pa;
        found = -1;
        h = 0; m = 0; f = 0; d = 0; r = 0; w = 0; pa = '0;
        if (!va[31])               seg = 2'd0;
        else if (va[30:29] == 2'b00) seg = 2'd1;
        else if (va[30:29] == 2'b01) seg = 2'd2;
        else                       seg = 2'd3;
        mapped = (seg == 2'd0) || (seg == 2'd3);
        if (!req) return 40'd0;
        if (!mapped) begin
            h = 1; pa = {3'b000, va[28:0]};
        end else begin
            for (int i = 63; i >= 0; i--)
                if (m_valid[i] && m_vpn[i] == va[31:12] && m_asid[i] == asid) found = i;
            if (found < 0) m = 1;
            else begin
                d = m_dirty[found]; r = m_ref[found]; w = m_rw[found];
                if (wr && !w) f = 1;
                else begin h = 1; pa = {m_pfn[found], va[11:0]}; end
            end
        end
        return {h, m, f, seg, d, r, w, pa};
    endfunction

    task automatic lookup(input logic req, input logic [31:0] va, input logic [5:0] asid,
                          input logic wr, input string tag);
        logic [39:0] e, a;
        @(negedge clk);
        lk_req = req; lk_va = va; lk_asid = asid; lk_write = wr;
        #1;
        e = expect_out(req, va, asid, wr);
        a = {lk_hit, lk_miss, lk_fault, lk_seg, lk_dirty, lk_ref, lk_rw, lk_pa};
        chk(a == e, tag, 64'(a), 64'(e));
    endtask

    task automatic wr_slot(input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                           input logic [19:0] pfn, input logic d, input logic r,
                           input logic v, input logic w, input logic fl);
        @(negedge clk);
        wr_en = 1; wr_idx = 6'(idx); wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
        wr_dirty = d; wr_ref = r; wr_valid = v; wr_rw = w; flush = fl;
        @(negedge clk);
        wr_en = 0; flush = 0;
        if (fl) model_clear();
        else begin
            m_valid[idx] = v; m_vpn[idx] = vpn; m_asid[idx] = asid; m_pfn[idx] = pfn;
            m_dirty[idx] = d; m_ref[idx] = r; m_rw[idx] = w;
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1;
        @(negedge clk);
        flush = 0;
        model_clear();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h5EED1234);
        model_clear();
        for (int i = 0; i < 64; i++) begin
            m_vpn[i] = '0; m_asid[i] = '0; m_pfn[i] = '0;
            m_dirty[i] = 0; m_ref[i] = 0; m_rw[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: empty after reset
        lookup(1, 32'h0001_0ABC, 6'd3, 0, "R1 user miss after reset");
        lookup(1, 32'hC000_1000, 6'd3, 0, "R1 kmapped miss after reset");
        // R2: region decode
        lookup(1, 32'h4000_0000, 6'd0, 0, "R2 region 01x");
        lookup(1, 32'hA000_0000, 6'd0, 0, "R2 region 101");
        lookup(1, 32'hE000_0000, 6'd0, 0, "R2 region 111");
        // R3: bypass windows
        lookup(1, 32'h8123_4567, 6'd0, 1, "R3 cached window");
        lookup(1, 32'hBFFF_FFFF, 6'd9, 0, "R3 uncached window");
        // R4, R7: mapped hit with attributes
        wr_slot(5, 20'h00010, 6'd3, 20'h12345, 1, 0, 1, 1, 0);
        lookup(1, 32'h0001_0ABC, 6'd3, 1, "R4 R7 hit slot5");
        // R5: identifier mismatch
        lookup(1, 32'h0001_0ABC, 6'd4, 0, "R5 other asid miss");
        // R6: read-only page
        wr_slot(6, 20'h00011, 6'd3, 20'hABCDE, 0, 1, 1, 0, 0);
        lookup(1, 32'h0001_1FFF, 6'd3, 0, "R6 read of read-only hits");
        lookup(1, 32'h0001_1FFF, 6'd3, 1, "R6 write to read-only faults");
        // R10: lowest index wins
        wr_slot(9, 20'h00010, 6'd3, 20'h55555, 0, 1, 1, 1, 0);
        lookup(1, 32'h0001_0123, 6'd3, 0, "R10 lowest index");
        // R9: invalidating write
        wr_slot(5, 20'h00010, 6'd3, 20'h12345, 0, 0, 0, 1, 0);
        lookup(1, 32'h0001_0123, 6'd3, 0, "R9 slot5 invalid, slot9 used");
        // R11: idle request
        lookup(0, 32'h0001_0123, 6'd3, 0, "R11 no request quiet");
        // R8: flush beats a simultaneous write
        wr_slot(12, 20'hC0002, 6'd1, 20'h0F0F0, 1, 1, 1, 1, 1);
        lookup(1, 32'hC000_2000, 6'd1, 0, "R8 write dropped by flush");
        lookup(1, 32'h0001_0123, 6'd3, 0, "R8 slot9 flushed");

        // Random mix of writes, flushes and lookups
        for (int n = 0; n < 4000; n++) begin
            int sel;
            sel = $urandom_range(99);
            if (sel < 25) begin
                wr_slot($urandom_range(1) ? int'($urandom_range(15)) : int'($urandom_range(63)),
                        pool[$urandom_range(7)], 6'($urandom_range(3)), 20'($urandom),
                        1'($urandom), 1'($urandom), ($urandom_range(9) != 0), 1'($urandom), 0);
            end else if (sel < 27) begin
                do_flush();
            end else begin
                lookup(($urandom_range(9) != 0),
                       {pool[$urandom_range(7)], 12'($urandom)},
                       6'($urandom_range(3)), 1'($urandom), "R4 R5 R6 R7 R10 random");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule